// File: doc/BRIEF.md
# Windowed Track Road Finder

This block searches a filled Hough-space tower array for candidate particle roads. The array is indexed by an angle bin and a curvature bin. Each tower holds one flag bit per input channel, set when that channel drew a line through the tower. Examining every tower in one cycle would need too much logic, so the block walks the angle axis in fixed-width windows. Each window covers every curvature row and is examined in one cycle. Only the towers of the current window, plus two guard columns on each side, are reduced to height codes.

Each tower's count of set channel bits becomes a 2-bit height class. A road is declared at a centre tower when its two neighbours on each side along the angle axis form a profile of at least "full-2, full-1, full, full-1, full-2". With eight channels this is 6, 7, 8, 7, 6. Roads found in a window are held in a pending set and handed out one per transfer over a valid/ready output. When the last window has been drained, a done flag rises and stays up until the next start.

The tower array is presented on a flat input bus and must be held stable from start to done.

Top module: `road_window_scan`

## Requirements
- R1: A tower's height class is 3 when all CH channel bits are set, 2 for CH-1 set bits, 1 for CH-2 set bits, and 0 for fewer. Tower (curvature c, angle a) occupies bits `accum[(c*NUM_ANGLE+a)*CH +: CH]`.
- R2: A road is reported at centre angle a in row c only when the classes at a-2, a-1, a, a+1, a+2 are at least 1, 2, 3, 2, 1. A missing channel at any of the five positions, or a non-full peak, means no road.
- R3: A reported road carries the angle bin and the curvature bin of the centre tower.
- R4: Angle positions below 0 or at or above NUM_ANGLE count as class 0. A centre within two bins of either end of the angle axis therefore never forms a road.
- R5: Window w covers centre angles w*WIN_W to w*WIN_W+WIN_W-1, and its classification also reads two towers beyond each end. A road whose profile straddles a window boundary is reported exactly once.
- R6: Roads leave in window order. Within a window they leave in order of rising curvature bin, then rising angle bin.
- R7: `roadValid` with `roadReady` low holds `roadValid`, `roadAngle` and `roadCurv` unchanged into the next cycle. Each cycle with both high transfers exactly one road.
- R8: `scanDone` rises only after the last window has been scanned and all of its roads transferred. It stays high with `roadValid` low until the next `start`, and falls in the cycle after that start is taken.
- R9: `start` is ignored while a scan is in progress.
- R10: After reset, `roadValid` and `scanDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan of the tower array |
| accum | input | NUM_ANGLE*NUM_CURV*CH | Tower channel bits, held stable during a scan |
| roadReady | input | 1 | Consumer accepts the presented road |
| roadValid | output | 1 | A road is presented |
| roadAngle | output | ANG_W | Angle bin of the road centre |
| roadCurv | output | CURV_W | Curvature bin of the road centre |
| scanDone | output | 1 | Scan finished and all roads sent |

## Verification
The hardest case to reach from the ports is a profile that straddles a window edge. Its centre lies in one window, but its outer towers are read only through the guard columns of that window. The stimulus places full profiles with centres on the last bin of one window and on the second bin of the next window, and checks that each road appears once. Profiles touching both ends of the angle axis are also applied. The order checks run with `roadReady` held low two cycles in every three, so that the pending set has to be held across stalls.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_DRAIN, ST_DONE} scan_state_e;

  typedef struct packed {
    logic loadWin;
    logic drainEn;
  } win_ctrl_t;

  function automatic logic [1:0] heightCode(input int cnt, input int full);
    logic [1:0] code;
    if (cnt >= full) code = 2'd3;
    else if (cnt == full - 1) code = 2'd2;
    else if (cnt == full - 2) code = 2'd1;
    else code = 2'd0;
    return code;
  endfunction
endpackage

// File: rtl/rf_window_path.sv
module rf_window_path
  import rf_pkg::*;
#(
  parameter int NUM_ANGLE = 24,
  parameter int NUM_CURV  = 4,
  parameter int CH        = 8,
  parameter int WIN_W     = 8,
  parameter int WIDX_W    = 2,
  parameter int ANG_W     = 5,
  parameter int CURV_W    = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  win_ctrl_t                       ctrl,
  input  logic [WIDX_W-1:0]               winIdx,
  input  logic [NUM_ANGLE*NUM_CURV*CH-1:0] accum,
  input  logic                            roadReady,
  output logic                            roadValid,
  output logic [ANG_W-1:0]                roadAngle,
  output logic [CURV_W-1:0]               roadCurv,
  output logic                            pendEmpty
);
  localparam int COLS   = WIN_W + 4;
  localparam int PEND   = NUM_CURV * WIN_W;
  localparam int PEND_W = (PEND > 1) ? $clog2(PEND) : 1;

  logic [NUM_CURV*COLS*2-1:0] codeFlat;
  logic [PEND-1:0]            matchVec;
  logic [PEND-1:0]            pendMask;
  logic [PEND_W-1:0]          selIdx;
  logic                       fire;

  for (genvar c = 0; c < NUM_CURV; c++) begin : g_row
    for (genvar j = 0; j < COLS; j++) begin : g_col
      logic [1:0] cd;
      always_comb begin
        int a;
        a = int'(winIdx) * WIN_W + j - 2;
        if (a < 0 || a >= NUM_ANGLE) cd = 2'd0;  // r4_ outside the axis
        else cd = heightCode($countones(accum[(c*NUM_ANGLE+a)*CH +: CH]), CH);
      end
      assign codeFlat[(c*COLS+j)*2 +: 2] = cd;
    end
    for (genvar k = 0; k < WIN_W; k++) begin : g_ctr
      assign matchVec[c*WIN_W+k] =
          (codeFlat[(c*COLS+k)*2   +: 2] >= 2'd1) &&
          (codeFlat[(c*COLS+k+1)*2 +: 2] >= 2'd2) &&
          (codeFlat[(c*COLS+k+2)*2 +: 2] == 2'd3) &&
          (codeFlat[(c*COLS+k+3)*2 +: 2] >= 2'd2) &&
          (codeFlat[(c*COLS+k+4)*2 +: 2] >= 2'd1);
    end
  end

  always_comb begin
    selIdx = '0;
    for (int i = PEND - 1; i >= 0; i--) begin
      if (pendMask[i]) selIdx = PEND_W'(i);
    end
  end

  assign pendEmpty = (pendMask == '0);
  assign roadValid = ctrl.drainEn && !pendEmpty;
  assign roadAngle = ANG_W'(int'(winIdx) * WIN_W + int'(selIdx) % WIN_W);
  assign roadCurv  = CURV_W'(int'(selIdx) / WIN_W);
  assign fire      = roadValid && roadReady;

  always_ff @(posedge clk) begin
    if (!rstN) pendMask <= '0;
    else if (ctrl.loadWin) pendMask <= matchVec;
    else if (fire) pendMask[selIdx] <= 1'b0;
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    roadValid && !roadReady |=> roadValid && $stable(roadAngle) && $stable(roadCurv));

  p_one_per_fire_r7: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> $countones(pendMask) == $countones($past(pendMask)) - 1);

  p_coord_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    roadValid |-> (int'(roadAngle) < NUM_ANGLE) && (int'(roadCurv) < NUM_CURV));
endmodule

// File: rtl/rf_scan_ctrl.sv
module rf_scan_ctrl
  import rf_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int WIDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              pendEmpty,
  input  logic              roadValid,
  output win_ctrl_t         ctrl,
  output logic [WIDX_W-1:0] winIdx,
  output logic              scanDone
);
  scan_state_e state;
  logic        lastWin;

  assign lastWin      = (int'(winIdx) == NUM_WIN - 1);
  assign ctrl.loadWin = (state == ST_LOAD);
  assign ctrl.drainEn = (state == ST_DRAIN);
  assign scanDone     = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      winIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state  <= ST_LOAD;
          winIdx <= '0;
        end
        ST_LOAD: state <= ST_DRAIN;
        ST_DRAIN: if (pendEmpty) begin
          if (lastWin) state <= ST_DONE;
          else begin
            winIdx <= winIdx + 1'b1;
            state  <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_load_then_drain_r5: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_LOAD |=> state == ST_DRAIN);

  p_win_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    int'(winIdx) < NUM_WIN);

  p_busy_stays_r9: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DRAIN && !pendEmpty |=> state == ST_DRAIN && $stable(winIdx));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> !roadValid);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    scanDone && !start |=> scanDone);
endmodule

// File: rtl/road_window_scan.sv
module road_window_scan
  import rf_pkg::*;
#(
  parameter int NUM_ANGLE = 24,
  parameter int NUM_CURV  = 4,
  parameter int CH        = 8,
  parameter int WIN_W     = 8,
  localparam int NUM_WIN  = (NUM_ANGLE + WIN_W - 1) / WIN_W,
  localparam int WIDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int ANG_W    = (NUM_ANGLE > 1) ? $clog2(NUM_ANGLE) : 1,
  localparam int CURV_W   = (NUM_CURV > 1) ? $clog2(NUM_CURV) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             start,
  input  logic [NUM_ANGLE*NUM_CURV*CH-1:0] accum,
  input  logic                             roadReady,
  output logic                             roadValid,
  output logic [ANG_W-1:0]                 roadAngle,
  output logic [CURV_W-1:0]                roadCurv,
  output logic                             scanDone
);
  win_ctrl_t         ctrl;
  logic [WIDX_W-1:0] winIdx;
  logic              pendEmpty;

  rf_scan_ctrl #(.NUM_WIN(NUM_WIN), .WIDX_W(WIDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pendEmpty(pendEmpty),
    .roadValid(roadValid), .ctrl(ctrl), .winIdx(winIdx), .scanDone(scanDone)
  );

  rf_window_path #(
    .NUM_ANGLE(NUM_ANGLE), .NUM_CURV(NUM_CURV), .CH(CH), .WIN_W(WIN_W),
    .WIDX_W(WIDX_W), .ANG_W(ANG_W), .CURV_W(CURV_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .winIdx(winIdx), .accum(accum),
    .roadReady(roadReady), .roadValid(roadValid), .roadAngle(roadAngle),
    .roadCurv(roadCurv), .pendEmpty(pendEmpty)
  );
endmodule

// File: tb/sim_road_window_scan.sv
module sim_road_window_scan;
  localparam int NA = 24, NC = 4, CH = 8, WW = 8;
  localparam int NW = (NA + WW - 1) / WW;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, roadReady = 1'b0;
  logic [NA*NC*CH-1:0] accum = '0;
  logic roadValid, scanDone;
  logic [4:0] roadAngle;
  logic [1:0] roadCurv;

  int errors = 0, checks = 0, cyc = 0;
  int hgt [NC][NA];
  int expA [NA*NC], expC [NA*NC], expN;
  int gotA [NA*NC], gotC [NA*NC], gotN;

  road_window_scan #(.NUM_ANGLE(NA), .NUM_CURV(NC), .CH(CH), .WIN_W(WW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .accum(accum), .roadReady(roadReady),
    .roadValid(roadValid), .roadAngle(roadAngle), .roadCurv(roadCurv), .scanDone(scanDone)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL R8 watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearH();
    for (int c = 0; c < NC; c++) for (int a = 0; a < NA; a++) hgt[c][a] = 0;
  endtask

  task automatic putProfile(input int c, input int ctr);
    int p [5] = '{6, 7, 8, 7, 6};
    for (int i = 0; i < 5; i++) hgt[c][ctr-2+i] = p[i];
  endtask

  // R1 bit layout: tower (c,a) at bits (c*NA+a)*CH; channels chosen rotated
  task automatic buildAccum();
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < NA; a++)
        for (int ch = 0; ch < CH; ch++)
          accum[(c*NA+a)*CH+ch] = (((ch + a + c) % CH) < hgt[c][a]);
  endtask

  function automatic int cls(input int c, input int a);
    if (a < 0 || a >= NA) return 0;  // R4
    if (hgt[c][a] >= CH) return 3;
    if (hgt[c][a] == CH-1) return 2;
    if (hgt[c][a] == CH-2) return 1;
    return 0;
  endfunction

  // expected roads in R6 order: window, then curvature, then angle
  task automatic model();
    expN = 0;
    for (int w = 0; w < NW; w++)
      for (int c = 0; c < NC; c++)
        for (int k = 0; k < WW; k++) begin
          int a = w*WW + k;
          if (a < NA && cls(c,a-2) >= 1 && cls(c,a-1) >= 2 && cls(c,a) == 3 &&
              cls(c,a+1) >= 2 && cls(c,a+2) >= 1) begin
            expA[expN] = a; expC[expN] = c; expN++;
          end
        end
  endtask

  task automatic runScan(input string tag, input int litCount, input bit throttle, input bit poke);
    bit pv = 0, pr = 0;
    int pa = 0, pc = 0;
    bit seenDone = 0;
    buildAccum();
    model();
    gotN = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(scanDone == 1'b0, "R8", {tag, " done cleared by start"}, scanDone, 0);
    for (int n = 0; n < 2000; n++) begin
      if (scanDone) begin seenDone = 1; break; end
      if (pv && !pr)
        chk(roadValid && roadAngle == 5'(pa) && roadCurv == 2'(pc), "R7",
            {tag, " stall hold"}, int'(roadAngle), pa);
      roadReady = throttle ? (n % 3 == 0) : 1'b1;
      if (roadValid && roadReady && gotN < NA*NC) begin
        gotA[gotN] = int'(roadAngle); gotC[gotN] = int'(roadCurv); gotN++;
      end
      pv = roadValid; pr = roadReady; pa = int'(roadAngle); pc = int'(roadCurv);
      start = (poke && (n == 2 || n == 5)) ? 1'b1 : 1'b0;  // R9 pokes mid-scan
      @(negedge clk);
    end
    start = 1'b0;
    roadReady = 1'b0;
    chk(seenDone, "R8", {tag, " done reached"}, seenDone, 1);
    chk(gotN == expN, "R2", {tag, " road count vs model"}, gotN, expN);
    chk(expN == litCount, "R2", {tag, " model count vs listed"}, expN, litCount);
    for (int i = 0; i < gotN && i < expN; i++) begin
      chk(gotA[i] == expA[i], "R3", {tag, " angle"}, gotA[i], expA[i]);
      chk(gotC[i] == expC[i], "R6", {tag, " curvature/order"}, gotC[i], expC[i]);
    end
  endtask

  task automatic t_reset();
    chk(roadValid == 1'b0, "R10", "reset valid", roadValid, 0);
    chk(scanDone == 1'b0, "R10", "reset done", scanDone, 0);
  endtask

  task automatic t_single();
    clearH(); putProfile(1, 11);
    runScan("R2 single", 1, 0, 0);
    chk(gotN == 1 && gotA[0] == 11 && gotC[0] == 1, "R3", "single at (11,1)", gotA[0], 11);
  endtask

  task automatic t_boundary();
    clearH(); putProfile(0, 7); putProfile(2, 16); putProfile(3, 9);
    runScan("R5 boundary", 3, 0, 0);
  endtask

  task automatic t_edges();
    clearH();
    hgt[3][0] = 7; hgt[3][1] = 8; hgt[3][2] = 7; hgt[3][3] = 6;
    putProfile(0, 2);
    hgt[1][21] = 6; hgt[1][22] = 7; hgt[1][23] = 8;
    putProfile(2, 21);
    runScan("R4 edges", 2, 0, 0);
  endtask

  task automatic t_nearMiss();
    clearH();
    hgt[0][3] = 5; hgt[0][4] = 7; hgt[0][5] = 8; hgt[0][6] = 7; hgt[0][7] = 6;
    hgt[1][3] = 6; hgt[1][4] = 7; hgt[1][5] = 7; hgt[1][6] = 7; hgt[1][7] = 6;
    hgt[2][3] = 6; hgt[2][4] = 6; hgt[2][5] = 8; hgt[2][6] = 7; hgt[2][7] = 6;
    for (int a = 10; a <= 16; a++) hgt[3][a] = 8;
    runScan("R1 near miss", 3, 0, 0);
  endtask

  task automatic t_orderThrottle();
    clearH(); putProfile(3, 4); putProfile(0, 5); putProfile(2, 12); putProfile(1, 20);
    putProfile(1, 10);
    runScan("R6 order", 5, 1, 1);
    chk(gotN == 5 && gotA[0] == 5 && gotC[0] == 0, "R6", "first road (5,0)", gotA[0], 5);
    chk(gotN == 5 && gotA[1] == 4 && gotC[1] == 3, "R6", "second road (4,3)", gotA[1], 4);
    chk(gotN == 5 && gotA[2] == 10 && gotC[2] == 1, "R9", "third road after pokes", gotA[2], 10);
  endtask

  task automatic t_doneHold();
    repeat (5) @(negedge clk);
    chk(scanDone == 1'b1, "R8", "done held", scanDone, 1);
    chk(roadValid == 1'b0, "R8", "no road while done", roadValid, 0);
  endtask

  task automatic t_empty();
    clearH();
    runScan("R2 empty", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_doneHold();
    t_boundary();
    t_edges();
    t_nearMiss();
    t_orderThrottle();
    t_doneHold();
    t_empty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule